// File: doc/BRIEF.md
# Nibble-Wide Handshaked Link Port

This block is one end of a point-to-point link that moves words between two processors over a 4-bit data bus. A strobe line marks each nibble and an acknowledge line paces the words. Static configuration inputs set the port up as the sending end or the receiving end. They also select single-rate or double-rate strobing, and whether a word is 32 or 48 bits wide. Both ends of a link must be given the same rate and width.

On the sending side, a host writes a word into a holding register. The port moves that word into a shift register when the far end acknowledges, and sends it most-significant nibble first. The holding register is then free for the next word at once.

On the receiving side, the port assembles incoming nibbles in a shift register and places each finished word in a holding register for the host to read. While that holding register is occupied, the port keeps its acknowledge low.

Top module: `lnk_port`

## Requirements
- R1: After reset, `txEmpty` is 1, `rxFull` is 0, and `lnkClkOut` and `lnkDataOut` are 0.
- R2: With `cfgTx`=1, `lnkDriveEn` is 1 and `lnkAckOut` is 0. With `cfgTx`=0, `lnkDriveEn`, `lnkClkOut` and `lnkDataOut` are 0, and `lnkAckOut` equals the inverse of `rxFull`.
- R3: With `cfgDouble`=0, a nibble is transferred only on a 0-to-1 transition of the strobe. The strobe is never high for two cycles in a row. A word appears 2 cycles per nibble after the cycle in which it is loaded, so a 32-bit word written in cycle 0 sets the receiver's `rxFull` in cycle 17.
- R4: With `cfgDouble`=1, every strobe transition carries a nibble. A 32-bit word written in cycle 0 sets `rxFull` in cycle 10.
- R5: Nibbles go out most significant first. With `cfgWide`=0, the word is `wrData[31:0]` and `rdData[47:32]` reads as 0.
- R6: With `cfgWide`=1, a word is 48 bits sent as 12 nibbles. A write in cycle 0 sets `rxFull` in cycle 25 at single rate and in cycle 14 at double rate.
- R7: The receiver holds acknowledge low while its holding register is full. A transmitter never starts a word while `lnkAckIn` is 0, so its strobe stays unchanged.
- R8: The transmit holding register empties in the cycle after the word starts shifting (`txEmpty` reads 0 in cycle 1 and 1 in cycle 2 after a write in cycle 0). A second word can then be written while the first is still being sent.
- R9: `rxFull` rises on the clock edge that captures the final nibble. A cycle with `rdEn`=1 presents the word on `rdData` and clears `rxFull` at the next edge.
- R10: A write while `txEmpty` is 0 is ignored. The held word is sent unchanged, and the dropped word never reaches the far end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both link ends |
| rstN | input | 1 | Active-low synchronous reset |
| cfgTx | input | 1 | 1 = transmitter, 0 = receiver |
| cfgDouble | input | 1 | 1 = nibble on both strobe transitions |
| cfgWide | input | 1 | 1 = 48-bit words, 0 = 32-bit words |
| wrEn | input | 1 | Host write strobe for transmit word |
| wrData | input | 48 | Transmit word |
| txEmpty | output | 1 | Transmit holding register free |
| rdEn | input | 1 | Host read strobe, releases received word |
| rdData | output | 48 | Received word |
| rxFull | output | 1 | Received word waiting |
| lnkDriveEn | output | 1 | Output enable for data and strobe lines |
| lnkDataOut | output | 4 | Nibble driven onto the link |
| lnkClkOut | output | 1 | Strobe driven onto the link |
| lnkAckOut | output | 1 | Acknowledge driven to the far end |
| lnkDataIn | input | 4 | Nibble from the link |
| lnkClkIn | input | 1 | Strobe from the link |
| lnkAckIn | input | 1 | Acknowledge from the far end |

## Verification
The bench builds two ports with the default parameters: 48-bit maximum width, 32-bit narrow width and 4-bit nibbles. It cross-wires the two ports so that either one can be the sender. With these defaults, the 8-nibble and 12-nibble framings and both strobe rates can be timed to the exact cycle. The longest transfer, 12 nibbles at single rate, is also in reach. Leaving the receiver unread stalls the link, which lets the bench test back-pressure, a dropped write and the reversed direction.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic {TX_IDLE, TX_SEND} txState_t;

  typedef struct packed {
    logic loadHold;
    logic startWord;
    logic emitNib;
    logic capNib;
    logic commitRx;
  } lnkStrobes_t;
endpackage

// File: rtl/lnk_ctrl.sv
module lnk_ctrl
  import lnk_pkg::*;
#(
  parameter int NIBS_NARROW = 8,
  parameter int NIBS_WIDE   = 12,
  parameter int CNT_W       = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgTx,
  input  logic        cfgDouble,
  input  logic        cfgWide,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        lnkClkIn,
  input  logic        lnkAckIn,
  output lnkStrobes_t strb,
  output logic        lnkClkOut,
  output logic        lnkAckOut,
  output logic        txEmpty,
  output logic        rxFull
);
  txState_t   txState;
  logic [CNT_W-1:0] txIdx, rxCnt, nibsThis, nibsLast;
  logic       strobeQ, txHoldFull, prevClk, rxHoldFull;
  logic       wrAccept, startWord, txDone, emitMid, capNib, commitRx;

  assign nibsThis = cfgWide ? CNT_W'(NIBS_WIDE) : CNT_W'(NIBS_NARROW);
  assign nibsLast = nibsThis - CNT_W'(1);

  // transmit side
  assign wrAccept  = cfgTx && wrEn && !txHoldFull;
  assign startWord = cfgTx && (txState == TX_IDLE) && txHoldFull && lnkAckIn;
  assign txDone    = (txState == TX_SEND) && (txIdx == nibsThis);
  assign emitMid   = (txState == TX_SEND) && !txDone && (cfgDouble || !strobeQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState    <= TX_IDLE;
      txIdx      <= '0;
      strobeQ    <= 1'b0;
      txHoldFull <= 1'b0;
    end else begin
      if (wrAccept)       txHoldFull <= 1'b1;
      else if (startWord) txHoldFull <= 1'b0;
      if (startWord) begin
        txState <= TX_SEND;
        txIdx   <= CNT_W'(1);
        strobeQ <= !strobeQ;
      end else if (txState == TX_SEND) begin
        if (txDone) begin
          txState <= TX_IDLE;
          strobeQ <= cfgDouble ? strobeQ : 1'b0;
        end else if (emitMid) begin
          strobeQ <= !strobeQ;
          txIdx   <= txIdx + CNT_W'(1);
        end else begin
          strobeQ <= 1'b0;
        end
      end
    end
  end

  // receive side
  assign capNib   = !cfgTx && (lnkClkIn != prevClk) && (cfgDouble || lnkClkIn);
  assign commitRx = capNib && (rxCnt == nibsLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevClk    <= 1'b0;
      rxCnt      <= '0;
      rxHoldFull <= 1'b0;
    end else begin
      prevClk <= lnkClkIn;
      if (commitRx)    rxCnt <= '0;
      else if (capNib) rxCnt <= rxCnt + CNT_W'(1);
      if (commitRx)    rxHoldFull <= 1'b1;
      else if (rdEn)   rxHoldFull <= 1'b0;
    end
  end

  assign strb.loadHold  = wrAccept;
  assign strb.startWord = startWord;
  assign strb.emitNib   = startWord || emitMid;
  assign strb.capNib    = capNib;
  assign strb.commitRx  = commitRx;

  assign lnkClkOut = cfgTx && strobeQ;
  assign lnkAckOut = !cfgTx && !rxHoldFull;
  assign txEmpty   = !txHoldFull;
  assign rxFull    = rxHoldFull;

  AST_RX_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rxCnt < nibsThis); // R6
  AST_NO_RX_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    commitRx |-> !rxHoldFull); // R7
  AST_START_ON_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_SEND && $past(txState) == TX_IDLE) |-> $past(lnkAckIn)); // R7
  AST_SINGLE_RATE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgDouble && $past(lnkClkOut)) |-> !lnkClkOut); // R3
  AST_VALID_ON_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxHoldFull) |-> ($past(rxCnt) == nibsLast)); // R9
endmodule

// File: rtl/lnk_datapath.sv
module lnk_datapath
  import lnk_pkg::*;
#(
  parameter int MAX_W    = 48,
  parameter int NARROW_W = 32,
  parameter int NIB_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWide,
  input  lnkStrobes_t      strb,
  input  logic [MAX_W-1:0] wrData,
  input  logic [NIB_W-1:0] lnkDataIn,
  output logic [NIB_W-1:0] dataOut,
  output logic [MAX_W-1:0] rdData
);
  localparam int PAD_W = MAX_W - NARROW_W;

  logic [MAX_W-1:0] txHoldQ, txShiftQ, rxShiftQ, rxHoldQ, aligned, assembled;
  logic [NIB_W-1:0] dataOutQ;

  assign aligned   = cfgWide ? txHoldQ : (txHoldQ << PAD_W);
  assign assembled = {rxShiftQ[MAX_W-NIB_W-1:0], lnkDataIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHoldQ  <= '0;
      txShiftQ <= '0;
      dataOutQ <= '0;
      rxShiftQ <= '0;
      rxHoldQ  <= '0;
    end else begin
      if (strb.loadHold) txHoldQ <= wrData;
      if (strb.startWord) begin
        dataOutQ <= aligned[MAX_W-1 -: NIB_W];
        txShiftQ <= aligned << NIB_W;
      end else if (strb.emitNib) begin
        dataOutQ <= txShiftQ[MAX_W-1 -: NIB_W];
        txShiftQ <= txShiftQ << NIB_W;
      end
      if (strb.capNib) rxShiftQ <= assembled;
      if (strb.commitRx)
        rxHoldQ <= cfgWide ? assembled : {{PAD_W{1'b0}}, assembled[NARROW_W-1:0]};
    end
  end

  assign dataOut = dataOutQ;
  assign rdData  = rxHoldQ;

  AST_RX_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitRx |=> $stable(rxHoldQ)); // R9
  AST_NARROW_ZERO_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWide && strb.commitRx) |=> (rdData[MAX_W-1:NARROW_W] == '0)); // R5
endmodule

// File: rtl/lnk_port.sv
module lnk_port
  import lnk_pkg::*;
#(
  parameter int MAX_W    = 48,
  parameter int NARROW_W = 32,
  parameter int NIB_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgTx,
  input  logic             cfgDouble,
  input  logic             cfgWide,
  input  logic             wrEn,
  input  logic [MAX_W-1:0] wrData,
  output logic             txEmpty,
  input  logic             rdEn,
  output logic [MAX_W-1:0] rdData,
  output logic             rxFull,
  output logic             lnkDriveEn,
  output logic [NIB_W-1:0] lnkDataOut,
  output logic             lnkClkOut,
  output logic             lnkAckOut,
  input  logic [NIB_W-1:0] lnkDataIn,
  input  logic             lnkClkIn,
  input  logic             lnkAckIn
);
  localparam int NIBS_WIDE   = MAX_W / NIB_W;
  localparam int NIBS_NARROW = NARROW_W / NIB_W;
  localparam int CNT_W       = $clog2(NIBS_WIDE + 1);

  lnkStrobes_t      strb;
  logic [NIB_W-1:0] dataOut;

  lnk_ctrl #(
    .NIBS_NARROW(NIBS_NARROW), .NIBS_WIDE(NIBS_WIDE), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgTx(cfgTx), .cfgDouble(cfgDouble),
    .cfgWide(cfgWide), .wrEn(wrEn), .rdEn(rdEn), .lnkClkIn(lnkClkIn),
    .lnkAckIn(lnkAckIn), .strb(strb), .lnkClkOut(lnkClkOut),
    .lnkAckOut(lnkAckOut), .txEmpty(txEmpty), .rxFull(rxFull)
  );

  lnk_datapath #(
    .MAX_W(MAX_W), .NARROW_W(NARROW_W), .NIB_W(NIB_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWide(cfgWide), .strb(strb),
    .wrData(wrData), .lnkDataIn(lnkDataIn), .dataOut(dataOut), .rdData(rdData)
  );

  assign lnkDriveEn = cfgTx;
  assign lnkDataOut = cfgTx ? dataOut : '0;

  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !txEmpty) |=> $stable(u_dp.txHoldQ)); // R10
  AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cfgTx |-> (lnkClkOut == 1'b0 && lnkDataOut == '0)); // R2
endmodule

// File: tb/lnk_port_bench.sv
module lnk_port_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic aTx = 1'b1, dbl = 1'b0, wide = 1'b0;
  logic aWr = 1'b0, bWr = 1'b0, aRd = 1'b0, bRd = 1'b0;
  logic [47:0] aWd = '0, bWd = '0;
  logic [47:0] aRdData, bRdData;
  logic aTxEmpty, bTxEmpty, aRxFull, bRxFull;
  logic aDrv, bDrv, aClkO, bClkO, aAckO, bAckO;
  logic [3:0] aDO, bDO;
  logic [3:0] aDI, bDI;
  logic aClkI, bClkI;
  int checks = 0, errors = 0;

  assign bDI = aDrv ? aDO : 4'h0;
  assign aDI = bDrv ? bDO : 4'h0;
  assign bClkI = aClkO;
  assign aClkI = bClkO;

  lnk_port u_lnk_port (
    .clk(clk), .rstN(rstN), .cfgTx(aTx), .cfgDouble(dbl), .cfgWide(wide),
    .wrEn(aWr), .wrData(aWd), .txEmpty(aTxEmpty), .rdEn(aRd), .rdData(aRdData),
    .rxFull(aRxFull), .lnkDriveEn(aDrv), .lnkDataOut(aDO), .lnkClkOut(aClkO),
    .lnkAckOut(aAckO), .lnkDataIn(aDI), .lnkClkIn(aClkI), .lnkAckIn(bAckO)
  );

  lnk_port u_peer (
    .clk(clk), .rstN(rstN), .cfgTx(!aTx), .cfgDouble(dbl), .cfgWide(wide),
    .wrEn(bWr), .wrData(bWd), .txEmpty(bTxEmpty), .rdEn(bRd), .rdData(bRdData),
    .rxFull(bRxFull), .lnkDriveEn(bDrv), .lnkDataOut(bDO), .lnkClkOut(bClkO),
    .lnkAckOut(bAckO), .lnkDataIn(bDI), .lnkClkIn(bClkI), .lnkAckIn(aAckO)
  );

  // line monitor: counts nibbles by the strobe rule of R3/R4
  logic monClk, monPrev = 1'b0;
  logic [3:0] monData, monFirst = '0;
  int monCount = 0;
  assign monClk  = aDrv ? aClkO : bClkO;
  assign monData = aDrv ? aDO : bDO;
  always @(posedge clk) begin
    if (!rstN) begin
      monPrev <= 1'b0; monCount <= 0;
    end else begin
      monPrev <= monClk;
      if (monClk != monPrev && (dbl || monClk)) begin
        if (monCount == 0) monFirst <= monData;
        monCount <= monCount + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic aIsTx, input logic d, input logic w);
    @(negedge clk);
    rstN = 1'b0; aTx = aIsTx; dbl = d; wide = w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    doReset(1'b1, 1'b0, 1'b0);
    chk("R1 txEmpty", 48'(aTxEmpty), 48'd1);
    chk("R1 rxFull", 48'(bRxFull), 48'd0);
    chk("R1 clkOut", 48'(aClkO), 48'd0);
    chk("R1 dataOut", 48'(aDO), 48'd0);
    chk("R2 tx driveEn", 48'(aDrv), 48'd1);
    chk("R2 tx ackOut", 48'(aAckO), 48'd0);
    chk("R2 rx driveEn", 48'(bDrv), 48'd0);
    chk("R2 rx ackOut", 48'(bAckO), 48'd1);
    chk("R2 rx quiet", {bClkO, bDO}, 48'd0);
  endtask

  task automatic t_transfer(input logic d, input logic w, input logic [47:0] data);
    int cnt, nibs, expLat;
    logic [47:0] expWord;
    logic [3:0] expFirst;
    string rq;
    doReset(1'b1, d, w);
    nibs = w ? 12 : 8;
    expLat = d ? nibs + 2 : 2 * nibs + 1;
    expWord = w ? data : {16'h0, data[31:0]};
    expFirst = w ? data[47:44] : data[31:28];
    rq = w ? "R6" : (d ? "R4" : "R3");
    aWd = data; aWr = 1'b1;
    @(negedge clk);
    aWr = 1'b0; cnt = 1;
    while (!bRxFull && cnt < 200) begin
      if (cnt == 1) chk("R8 txEmpty after write", 48'(aTxEmpty), 48'd0);
      if (cnt == 2) chk("R8 txEmpty after start", 48'(aTxEmpty), 48'd1);
      @(negedge clk); cnt++;
    end
    chk({rq, " latency"}, 48'(cnt), 48'(expLat));
    chk({rq, " nibble count"}, 48'(monCount), 48'(nibs));
    chk("R5 first nibble", 48'(monFirst), 48'(expFirst));
    chk("R7 ack low while full", 48'(bAckO), 48'd0);
    bRd = 1'b1;
    chk("R9 rdData", bRdData, expWord);
    @(negedge clk);
    bRd = 1'b0;
    chk("R9 rxFull cleared", 48'(bRxFull), 48'd0);
  endtask

  task automatic t_backpressure();
    int cnt, changes;
    logic lastClk;
    doReset(1'b1, 1'b1, 1'b0);
    aWd = 48'h0000_1234_5678; aWr = 1'b1;
    @(negedge clk); aWr = 1'b0;
    cnt = 0;
    while (!aTxEmpty && cnt < 50) begin @(negedge clk); cnt++; end
    aWd = 48'h0000_9ABC_DEF0; aWr = 1'b1;
    @(negedge clk); aWr = 1'b0;
    chk("R8 second word accepted", 48'(aTxEmpty), 48'd0);
    cnt = 0;
    while (!bRxFull && cnt < 200) begin @(negedge clk); cnt++; end
    chk("R8 first word arrived", 48'(bRxFull), 48'd1);
    aWd = 48'h0000_DEAD_BEEF; aWr = 1'b1;
    @(negedge clk); aWr = 1'b0;
    changes = 0; lastClk = aClkO;
    repeat (30) begin
      @(negedge clk);
      if (aClkO != lastClk) changes++;
      lastClk = aClkO;
    end
    chk("R7 strobe stalled", 48'(changes), 48'd0);
    chk("R7 ack low", 48'(bAckO), 48'd0);
    chk("R10 txEmpty still low", 48'(aTxEmpty), 48'd0);
    bRd = 1'b1;
    chk("R9 first word", bRdData, 48'h0000_1234_5678);
    @(negedge clk); bRd = 1'b0;
    cnt = 0;
    while (!bRxFull && cnt < 200) begin @(negedge clk); cnt++; end
    chk("R10 held word unchanged", bRdData, 48'h0000_9ABC_DEF0);
    bRd = 1'b1;
    @(negedge clk); bRd = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10 dropped word absent", 48'(bRxFull), 48'd0);
    chk("R10 tx idle", 48'(aTxEmpty), 48'd1);
  endtask

  task automatic t_reverse();
    int cnt;
    doReset(1'b0, 1'b0, 1'b1);
    chk("R2 reversed driveEn", 48'(aDrv), 48'd0);
    chk("R2 reversed ackOut", 48'(aAckO), 48'd1);
    chk("R2 reversed peer drives", 48'(bDrv), 48'd1);
    bWd = 48'hFEDC_BA98_7654; bWr = 1'b1;
    @(negedge clk); bWr = 1'b0;
    cnt = 1;
    while (!aRxFull && cnt < 200) begin @(negedge clk); cnt++; end
    chk("R6 reversed latency", 48'(cnt), 48'd25);
    chk("R6 reversed nibbles", 48'(monCount), 48'd12);
    chk("R2 ack follows rxFull", 48'(aAckO), 48'd0);
    aRd = 1'b1;
    chk("R6 reversed word", aRdData, 48'hFEDC_BA98_7654);
    @(negedge clk); aRd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_transfer(1'b0, 1'b0, 48'hFFFF_A5C3_1E7F);
    t_transfer(1'b1, 1'b0, 48'h0000_8421_F00D);
    t_transfer(1'b0, 1'b1, 48'hC0FF_EE12_3456);
    t_transfer(1'b1, 1'b1, 48'h7BAD_5EED_0A9E);
    t_backpressure();
    t_reverse();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule